// File: doc/BRIEF.md
# Serial configuration frame checker

This block sits on a bit-serial configuration input and checks the structure of the stream while it arrives. The stream carries one bit per clock, and a strobe qualifies each bit. Before the header, any number of idle ones may appear; the block ignores them. The header itself is a four-bit preamble code, then a 24-bit length count and a four-bit run of ones. A fixed number of data frames follows the header. Each frame opens with a zero start bit, carries `FRAME_BITS` payload bits and closes with a check field. An eight-bit postamble ends the stream.

A build-time parameter selects one of two check schemes. In the first, every frame closes with a constant four-bit code. In the second, a CRC register runs across the stream without restarting between frames. Each frame is then closed by a four-bit slice of that register, and the final frame by a wider 11-bit slice. The payload bits of every frame appear on a registered output with a valid flag.

The block raises a done flag only when the postamble is correct and the declared length matches the number of bits actually received. On the first mismatch it pulls an active-low error output low and halts. It stays halted until a synchronous reset arrives, and that reset stands in for a fresh programming attempt.

Top module: `cfg_frame_checker`

## Requirements
- R1: While reset is high and in the first cycle after it is released, init_n_o is 1 and done_o and data_valid_o are 0.
- R2: Ones received before the header are ignored, whatever their number (zero included). The first zero received starts the preamble, and the preamble must read 0,0,1,0 in arrival order. Any other value is an error.
- R3: After the preamble come 24 length-count bits, most significant first, and then four fill bits that must all be 1. A zero in the fill is an error.
- R4: Each of the NUM_FRAMES frames starts with one bit that must be 0. A 1 in that position is an error.
- R5: Each accepted payload bit appears on data_o with data_valid_o high for exactly one cycle, starting the cycle after the edge that took it. Bits appear in arrival order. Cycles in which bit_valid_i is low change nothing, whatever bit_i holds.
- R6: With USE_CRC=0, every frame, including the last, ends with the four bits 0,1,1,0 in arrival order. A deviation is an error.
- R7: With USE_CRC=1, a 16-bit CRC register is involved. It uses generator 0x8005 (x^16+x^15+x^2+1) and shifts toward the MSB, with feedback equal to crc[15] XOR the input bit. It is cleared when the first preamble bit arrives. It takes in the start bit and payload bits of every frame but not the check bits. Every frame except the last must end with crc[3:0], with crc[3] arriving first.
- R8: With USE_CRC=1, the last frame ends with 11 check bits that must equal crc[10:0], with crc[10] arriving first. This wider check also covers the final seven payload bits.
- R9: After the last frame, the postamble must read 0,1,1,1,1,1,1,1. The length count must equal the number of bits from the first fill bit through the last postamble bit. If both hold, done_o rises in the cycle after the final postamble bit. Otherwise the block flags an error there.
- R10: On an error, init_n_o falls in the cycle after the offending bit. From then on, done_o and data_valid_o stay 0 and all input is ignored until reset.
- R11: Once done_o is 1, it stays 1 and any further input has no effect on the outputs until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; also leaves the error wait state |
| bit_i | input | 1 | Serial stream bit |
| bit_valid_i | input | 1 | Qualifies bit_i in this cycle |
| data_o | output | 1 | Payload bit taken from the current frame |
| data_valid_o | output | 1 | data_o holds a new payload bit |
| done_o | output | 1 | Stream fully accepted |
| init_n_o | output | 1 | Low after a detected error |

## Verification
Some properties hold in every cycle, and the assertions check those. Done and error never occur together, and each one sticks once set. Payload output never appears without a strobe the cycle before, and never after an error. Done only rises right after a strobed bit. Between payload bits the CRC register holds its value, and a clear leaves it at zero. Whether a stream is accepted or rejected depends on whole bit sequences: a single corrupted preamble, fill, start, check or postamble bit, or a wrong length count. Only the bench's scenarios can show those outcomes, together with the exact cycle in which done or the error appears and the ordering of the payload bits.

// File: rtl/cfg_frame_pkg.sv
package cfg_frame_pkg;

   typedef enum logic [3:0] {
      ST_HUNT,
      ST_PRE,
      ST_LEN,
      ST_FILL,
      ST_START,
      ST_DATA,
      ST_TRAIL,
      ST_POST,
      ST_DONE,
      ST_WAIT
   } cfg_state_e;

   localparam int          LEN_BITS     = 24;
   localparam int          SHORT_CHECK  = 4;
   localparam int          LONG_CHECK   = 11;
   localparam int          CRC_W        = 16;
   localparam logic [15:0] CRC_POLY     = 16'h8005;
   localparam logic [3:0]  PRE_CODE     = 4'b0010;
   localparam logic [3:0]  FILL_CODE    = 4'b1111;
   localparam logic [3:0]  TRAIL_CODE   = 4'b0110;
   localparam logic [7:0]  POST_CODE    = 8'b0111_1111;

endpackage

// File: rtl/cfg_crc_serial.sv
module cfg_crc_serial
   import cfg_frame_pkg::*;
#(
   parameter int          W    = CRC_W,
   parameter logic [15:0] POLY = CRC_POLY
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr_i,
   input  logic         en_i,
   input  logic         din_i,
   output logic [W-1:0] crc_o
);

   if (W < 12 || W > 16) begin : g_bad_w
      $error("cfg_crc_serial: W must lie in 12..16");
   end

   logic [W-1:0] crc_q;
   logic         fb;

   assign fb = crc_q[W-1] ^ din_i;

   always_ff @(posedge clk) begin
      if (rst || clr_i) begin
         crc_q <= '0;
      end else if (en_i) begin
         crc_q <= {crc_q[W-2:0], 1'b0} ^ (fb ? POLY[W-1:0] : '0);
      end
   end

   assign crc_o = crc_q;

   // R7: register only moves on enabled bits
   p_crc_hold_r7 : assert property (@(posedge clk) disable iff (rst)
      (!en_i && !clr_i) |=> $stable(crc_q));

   // R7: clear leaves zero
   p_crc_clear_r7 : assert property (@(posedge clk) disable iff (rst)
      clr_i |=> (crc_q == '0));

endmodule

// File: rtl/cfg_expect_bit.sv
module cfg_expect_bit
   import cfg_frame_pkg::*;
#(
   parameter int FRAME_BITS = 8,
   parameter bit USE_CRC    = 1'b0,
   parameter int POSW       = 5
) (
   input  cfg_state_e      state_i,
   input  logic [POSW-1:0] pos_i,
   input  logic            last_i,
   input  logic [10:0]     crc_i,
   output logic            exp_o,
   output logic            seg_end_o
);

   localparam logic [POSW-1:0] END_SHORT = POSW'(SHORT_CHECK - 1);
   localparam logic [POSW-1:0] END_LONG  = POSW'(LONG_CHECK - 1);
   localparam logic [POSW-1:0] END_LEN   = POSW'(LEN_BITS - 1);
   localparam logic [POSW-1:0] END_DATA  = POSW'(FRAME_BITS - 1);
   localparam logic [POSW-1:0] END_POST  = POSW'(7);

   logic            trail_exp;
   logic [POSW-1:0] trail_end;

   if (USE_CRC) begin : g_crc_trail
      logic [3:0]  sh_short;
      logic [10:0] sh_long;
      always_comb begin
         sh_short  = crc_i[3:0] << pos_i;
         sh_long   = crc_i << pos_i;
         trail_exp = last_i ? sh_long[10] : sh_short[3];
         trail_end = last_i ? END_LONG : END_SHORT;
      end
   end else begin : g_const_trail
      logic       unused_crc;
      logic       unused_last;
      logic [3:0] sh_code;
      assign unused_crc  = ^crc_i;
      assign unused_last = last_i;
      always_comb begin
         sh_code   = TRAIL_CODE << pos_i;
         trail_exp = sh_code[3];
         trail_end = END_SHORT;
      end
   end

   logic [3:0] sh_pre;
   logic [3:0] sh_fill;
   logic [7:0] sh_post;

   always_comb begin
      sh_pre    = PRE_CODE << pos_i;
      sh_fill   = FILL_CODE << pos_i;
      sh_post   = POST_CODE << pos_i;
      exp_o     = 1'b0;
      seg_end_o = 1'b0;
      unique case (state_i)
         ST_PRE:   begin exp_o = sh_pre[3];  seg_end_o = (pos_i == END_SHORT); end
         ST_LEN:   begin exp_o = 1'b0;       seg_end_o = (pos_i == END_LEN);   end
         ST_FILL:  begin exp_o = sh_fill[3]; seg_end_o = (pos_i == END_SHORT); end
         ST_START: begin exp_o = 1'b0;       seg_end_o = 1'b1;                 end
         ST_DATA:  begin exp_o = 1'b0;       seg_end_o = (pos_i == END_DATA);  end
         ST_TRAIL: begin exp_o = trail_exp;  seg_end_o = (pos_i == trail_end); end
         ST_POST:  begin exp_o = sh_post[7]; seg_end_o = (pos_i == END_POST);  end
         default:  begin exp_o = 1'b1;       seg_end_o = 1'b0;                 end
      endcase
   end

endmodule

// File: rtl/cfg_frame_checker.sv
module cfg_frame_checker
   import cfg_frame_pkg::*;
#(
   parameter int FRAME_BITS = 8,
   parameter int NUM_FRAMES = 3,
   parameter bit USE_CRC    = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic bit_i,
   input  logic bit_valid_i,
   output logic data_o,
   output logic data_valid_o,
   output logic done_o,
   output logic init_n_o
);

   localparam int POS_MAX = (FRAME_BITS > LEN_BITS) ? FRAME_BITS : LEN_BITS;
   localparam int POSW    = $clog2(POS_MAX + 1);
   localparam int FCW     = $clog2(NUM_FRAMES + 1);
   localparam logic [FCW-1:0] LAST_FRAME = FCW'(NUM_FRAMES - 1);

   if (FRAME_BITS < 7) begin : g_bad_frame
      $error("cfg_frame_checker: FRAME_BITS below 7 cannot hold the final check span");
   end
   if (NUM_FRAMES < 1) begin : g_bad_count
      $error("cfg_frame_checker: NUM_FRAMES must be at least 1");
   end

   cfg_state_e            state_q;
   logic [POSW-1:0]       pos_q;
   logic [FCW-1:0]        frame_q;
   logic [LEN_BITS-1:0]   len_q;
   logic [LEN_BITS-1:0]   bcnt_q;
   logic                  data_q;
   logic                  dv_q;
   logic                  done_q;
   logic                  err_q;

   logic [CRC_W-1:0]      crc_w;
   logic                  crc_clr;
   logic                  crc_en;
   logic                  exp_bit;
   logic                  seg_end;
   logic                  last_frame;
   logic                  mismatch;
   logic                  unused_crc_hi;

   assign last_frame    = (frame_q == LAST_FRAME);
   assign crc_clr       = bit_valid_i && (state_q == ST_HUNT) && !bit_i;
   assign crc_en        = bit_valid_i && ((state_q == ST_START) || (state_q == ST_DATA));
   assign mismatch      = (bit_i != exp_bit);
   assign unused_crc_hi = ^crc_w[CRC_W-1:LONG_CHECK];

   cfg_crc_serial #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
      .clk   (clk),
      .rst   (rst),
      .clr_i (crc_clr),
      .en_i  (crc_en),
      .din_i (bit_i),
      .crc_o (crc_w)
   );

   cfg_expect_bit #(.FRAME_BITS(FRAME_BITS), .USE_CRC(USE_CRC), .POSW(POSW)) u_exp (
      .state_i   (state_q),
      .pos_i     (pos_q),
      .last_i    (last_frame),
      .crc_i     (crc_w[LONG_CHECK-1:0]),
      .exp_o     (exp_bit),
      .seg_end_o (seg_end)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_HUNT;
         pos_q   <= '0;
         frame_q <= '0;
         len_q   <= '0;
         bcnt_q  <= '0;
         data_q  <= 1'b0;
         dv_q    <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         dv_q <= 1'b0;
         if (bit_valid_i) begin
            if (state_q inside {ST_FILL, ST_START, ST_DATA, ST_TRAIL, ST_POST}) begin
               bcnt_q <= bcnt_q + 1'b1;
            end
            unique case (state_q)
               ST_HUNT: begin
                  if (!bit_i) begin
                     state_q <= ST_PRE;
                     pos_q   <= POSW'(1);
                  end
               end
               ST_LEN: begin
                  len_q  <= {len_q[LEN_BITS-2:0], bit_i};
                  bcnt_q <= '0;
                  pos_q  <= seg_end ? '0 : pos_q + 1'b1;
                  if (seg_end) state_q <= ST_FILL;
               end
               ST_DATA: begin
                  data_q <= bit_i;
                  dv_q   <= 1'b1;
                  pos_q  <= seg_end ? '0 : pos_q + 1'b1;
                  if (seg_end) state_q <= ST_TRAIL;
               end
               ST_PRE, ST_FILL, ST_START, ST_TRAIL, ST_POST: begin
                  if (mismatch) begin
                     state_q <= ST_WAIT;
                     err_q   <= 1'b1;
                  end else if (!seg_end) begin
                     pos_q <= pos_q + 1'b1;
                  end else begin
                     pos_q <= '0;
                     unique case (state_q)
                        ST_PRE:   state_q <= ST_LEN;
                        ST_FILL:  state_q <= ST_START;
                        ST_START: state_q <= ST_DATA;
                        ST_TRAIL: begin
                           frame_q <= frame_q + 1'b1;
                           state_q <= last_frame ? ST_POST : ST_START;
                        end
                        default: begin
                           if (bcnt_q + 1'b1 == len_q) begin
                              state_q <= ST_DONE;
                              done_q  <= 1'b1;
                           end else begin
                              state_q <= ST_WAIT;
                              err_q   <= 1'b1;
                           end
                        end
                     endcase
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign data_o       = data_q;
   assign data_valid_o = dv_q;
   assign done_o       = done_q;
   assign init_n_o     = !err_q;

   // R10: done and error exclude each other
   p_done_err_excl_r10 : assert property (@(posedge clk) disable iff (rst)
      !(done_o && !init_n_o));

   // R10: error is held until reset
   p_err_sticky_r10 : assert property (@(posedge clk) disable iff (rst)
      !init_n_o |=> !init_n_o);

   // R10: no payload once in the wait state
   p_quiet_after_err_r10 : assert property (@(posedge clk) disable iff (rst)
      !init_n_o |-> !data_valid_o);

   // R11: done is held until reset
   p_done_sticky_r11 : assert property (@(posedge clk) disable iff (rst)
      done_o |=> done_o);

   // R5: payload only follows a strobed bit
   p_dv_strobe_r5 : assert property (@(posedge clk) disable iff (rst)
      data_valid_o |-> $past(bit_valid_i));

   // R9: done only rises right after a strobed bit
   p_done_rise_r9 : assert property (@(posedge clk) disable iff (rst)
      $rose(done_o) |-> $past(bit_valid_i));

endmodule

// File: tb/sim_cfg_frame_checker.sv
module sim_cfg_frame_checker;

   localparam int NB = 8;
   localparam int NF = 3;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic bit_d = 1'b0;
   logic vld0 = 1'b0;
   logic vld1 = 1'b0;
   logic d0, dv0, dn0, in0;
   logic d1, dv1, dn1, in1;

   always #5 clk = ~clk;

   cfg_frame_checker #(.FRAME_BITS(NB), .NUM_FRAMES(NF), .USE_CRC(1'b0)) u0 (
      .clk(clk), .rst(rst), .bit_i(bit_d), .bit_valid_i(vld0),
      .data_o(d0), .data_valid_o(dv0), .done_o(dn0), .init_n_o(in0));

   cfg_frame_checker #(.FRAME_BITS(NB), .NUM_FRAMES(NF), .USE_CRC(1'b1)) u1 (
      .clk(clk), .rst(rst), .bit_i(bit_d), .bit_valid_i(vld1),
      .data_o(d1), .data_valid_o(dv1), .done_o(dn1), .init_n_o(in1));

   int   nchk = 0;
   int   nfail = 0;
   int   mode_sel = 0;
   logic strm [0:511];
   int   slen;
   logic dexp [0:63];
   int   nexp;
   logic dgot [0:63];
   int   ngot;

   // {mode, fault[2:0], gap, lead[4:0], seed[7:0]}
   localparam logic [17:0] SCN [0:12] = '{
      {1'b0, 3'd0, 1'b0, 5'd8,  8'hA5},
      {1'b0, 3'd0, 1'b1, 5'd0,  8'h3C},
      {1'b1, 3'd0, 1'b0, 5'd8,  8'h5A},
      {1'b1, 3'd0, 1'b1, 5'd19, 8'hF0},
      {1'b0, 3'd1, 1'b0, 5'd8,  8'h11},
      {1'b0, 3'd2, 1'b0, 5'd3,  8'h22},
      {1'b1, 3'd3, 1'b0, 5'd8,  8'h33},
      {1'b0, 3'd4, 1'b0, 5'd8,  8'h44},
      {1'b1, 3'd4, 1'b1, 5'd8,  8'h55},
      {1'b1, 3'd5, 1'b0, 5'd2,  8'h66},
      {1'b0, 3'd5, 1'b0, 5'd8,  8'h77},
      {1'b1, 3'd6, 1'b0, 5'd8,  8'h88},
      {1'b0, 3'd7, 1'b0, 5'd8,  8'h99}
   };

   always @(negedge clk) begin
      if (!rst && (mode_sel == 0 ? dv0 : dv1)) begin
         if (ngot < 64) dgot[ngot] = (mode_sel == 0) ? d0 : d1;
         ngot++;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic push(input logic b);
      strm[slen] = b;
      slen++;
   endtask

   function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
      logic fb;
      fb = c[15] ^ b;
      return {c[14:0], 1'b0} ^ (fb ? 16'h8005 : 16'h0000);
   endfunction

   task automatic build(input int mode, input int fault, input int lead, input logic [7:0] seed);
      logic [15:0] crc;
      logic [23:0] len;
      logic        b;
      int          tl;
      slen = 0;
      nexp = 0;
      crc  = '0;
      repeat (lead) push(1'b1);
      push(1'b0); push(1'b0); push(fault == 1 ? 1'b0 : 1'b1); push(1'b0);
      len = 24'(4 + NF * (1 + NB + 4) + (mode != 0 ? 7 : 0) + 8 + (fault == 7 ? 1 : 0));
      for (int k = 23; k >= 0; k--) push(len[k]);
      for (int k = 0; k < 4; k++) push((fault == 2 && k == 0) ? 1'b0 : 1'b1);
      for (int f = 0; f < NF; f++) begin
         b = (fault == 3 && f == 1) ? 1'b1 : 1'b0;
         push(b);
         crc = crc_step(crc, b);
         for (int j = 0; j < NB; j++) begin
            b = seed[(j + f) % 8] ^ f[0];
            push(b);
            dexp[nexp] = b;
            nexp++;
            crc = crc_step(crc, b);
         end
         tl = (mode != 0 && f == NF - 1) ? 11 : 4;
         for (int k = 0; k < tl; k++) begin
            b = (mode != 0) ? crc[tl - 1 - k] : ((k == 1 || k == 2) ? 1'b1 : 1'b0);
            if (fault == 4 && f == 0 && k == 0) b = ~b;
            if (fault == 5 && f == NF - 1 && k == tl - 1) b = ~b;
            push(b);
         end
      end
      for (int k = 0; k < 8; k++) begin
         b = (k == 0) ? 1'b0 : 1'b1;
         if (fault == 6 && k == 7) b = ~b;
         push(b);
      end
   endtask

   task automatic do_reset();
      rst  = 1'b1;
      vld0 = 1'b0;
      vld1 = 1'b0;
      repeat (3) @(negedge clk);
      rst  = 1'b0;
      ngot = 0;
   endtask

   task automatic run_part(input int mode, input int gap, input int from, input int upto);
      mode_sel = mode;
      for (int i = from; i < upto; i++) begin
         @(negedge clk);
         bit_d = strm[i];
         vld0  = (mode == 0);
         vld1  = (mode != 0);
         if (gap != 0 && (i % 2) == 1) begin
            @(negedge clk);
            vld0  = 1'b0;
            vld1  = 1'b0;
            bit_d = ~strm[i];
         end
      end
      @(negedge clk);
      vld0 = 1'b0;
      vld1 = 1'b0;
      @(negedge clk);
   endtask

   function automatic string req_of(input int fault, input int mode);
      case (fault)
         0: return (mode != 0) ? "R7 R8 R5 R2" : "R6 R5 R2";
         1: return "R2";
         2: return "R3";
         3: return "R4";
         4: return (mode != 0) ? "R7" : "R6";
         5: return (mode != 0) ? "R8" : "R6";
         default: return "R9";
      endcase
   endfunction

   initial begin
      // R1: reset state
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk(in0 == 1'b1 && in1 == 1'b1, "R1 init_n in reset", in0, 1);
      chk(dn0 == 1'b0 && dv0 == 1'b0, "R1 done/valid in reset", dn0, 0);
      rst = 1'b0;
      ngot = 0;
      @(negedge clk);
      chk(in0 == 1'b1 && dn0 == 1'b0 && dv0 == 1'b0, "R1 after release", in0, 1);

      // table-driven scenarios
      for (int i = 0; i < 13; i++) begin
         int mode, fault, gap, lead, bad;
         logic okd, okn;
         mode  = int'(SCN[i][17]);
         fault = int'(SCN[i][16:14]);
         gap   = int'(SCN[i][13]);
         lead  = int'(SCN[i][12:8]);
         do_reset();
         build(mode, fault, lead, SCN[i][7:0]);
         run_part(mode, gap, 0, slen);
         okd = (mode == 0) ? dn0 : dn1;
         okn = (mode == 0) ? in0 : in1;
         chk(okd == (fault == 0), {req_of(fault, mode), " done"}, okd, fault == 0);
         chk(okn == (fault == 0), {req_of(fault, mode), " init_n R10"}, okn, fault == 0);
         if (fault == 0) begin
            chk(ngot == nexp, "R5 payload count", ngot, nexp);
            bad = 0;
            for (int k = 0; k < nexp && k < 64; k++) if (dgot[k] != dexp[k]) bad++;
            chk(bad == 0, "R5 payload order", bad, 0);
         end
      end

      // R9 / R11: done timing and input ignored after done
      do_reset();
      build(0, 0, 8, 8'hC3);
      run_part(0, 0, 0, slen - 1);
      chk(dn0 == 1'b0, "R9 done before last postamble bit", dn0, 0);
      run_part(0, 0, slen - 1, slen);
      chk(dn0 == 1'b1, "R9 done after last postamble bit", dn0, 1);
      ngot = 0;
      slen = 0;
      for (int k = 0; k < 40; k++) push(k[0]);
      run_part(0, 0, 0, slen);
      chk(dn0 == 1'b1 && in0 == 1'b1, "R11 done held", dn0, 1);
      chk(ngot == 0, "R11 no payload after done", ngot, 0);

      // R10: error cycle and wait state
      do_reset();
      build(1, 6, 4, 8'h0F);
      run_part(1, 0, 0, slen - 1);
      chk(in1 == 1'b1, "R10 init_n before bad bit", in1, 1);
      run_part(1, 0, slen - 1, slen);
      chk(in1 == 1'b0, "R10 init_n after bad bit", in1, 0);
      do_reset();
      build(0, 2, 8, 8'h5A);
      run_part(0, 0, 0, slen);
      build(0, 0, 8, 8'h5A);
      run_part(0, 0, 0, slen);
      chk(in0 == 1'b0 && dn0 == 1'b0, "R10 wait state ignores a good stream", in0, 0);
      chk(ngot == 0, "R10 no payload in wait state", ngot, 0);
      do_reset();
      run_part(0, 0, 0, slen);
      chk(dn0 == 1'b1 && in0 == 1'b1, "R10 reset leaves wait state", dn0, 1);

      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

endmodule